// File: doc/BRIEF.md
# Cubic Spline Accumulator Interpolator

This block turns a set of cubic polynomial coefficients into a stream of signed 16-bit DAC samples. It does no multiplication. A chain of four accumulators is updated by forward differences: on each evolution step, every accumulator adds the value of the next higher-order one. The host must pre-compensate its continuous-time coefficients for this discrete scheme. The slope then already contains half the curvature plus one sixth of the jerk, and the curvature already contains the jerk.

A line starts with a one-cycle load strobe. The strobe captures an offset (one word), a slope (two words) and curvature and jerk terms (three words each). It also captures a rate exponent. The accumulators then evolve once every 2^exponent cycles, counting only cycles in which the line is active. When the line is inactive, the output and the rate count are frozen. Each coefficient is a fixed-point number with one fractional word per word beyond the first. All accumulators are therefore aligned to a common three-word width, and the sample is the top word of the order-0 accumulator. With full scale 2^15 mapped to 10 V, one LSB is about 305 µV.

Top module: `spline_interp`

## Requirements
- R1: While reset is asserted, and after its release until the first load, `sample` is 0.
- R2: A cycle with `load` high captures all coefficients and `shift`. In the next cycle `sample` equals `coef0`, whatever `active` was. A load never steps in the cycle it occurs.
- R3: An evolution step updates, using the values from before the step, order0 += order1, order1 += order2 and order2 += order3. Order3 never changes within a line.
- R4: The accumulators are 48 bits wide. `coef0` occupies bits 47:32, `coef1` bits 47:16 and `coef2`/`coef3` bits 47:0. `sample` is bits 47:32 of order0. For example, a slope of 0x0001_0000 adds exactly 1 LSB per step, and 0x0000_8000 adds 1 LSB every two steps.
- R5: With captured exponent s, a step happens on every 2^s-th active cycle counted from the load. With s = 0, every active cycle steps. The `shift` input is ignored in cycles without `load`.
- R6: In a cycle with `active` low and `load` low, no step occurs: `sample` holds and the rate count pauses, then resumes where it stopped.
- R7: All accumulator arithmetic wraps modulo 2^48. For example, offset 0x7FFF with slope +1 LSB gives 0x8000 after one step, and a slope of 0xFFFF_0000 decrements by 1 LSB per step.
- R8: With nonzero curvature and jerk terms, every sample equals the top word of a 48-bit forward-difference model of R3 and R4 at the step count given by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Line start strobe; captures coefficients and shift |
| active | input | 1 | Line running; enables the rate count and evolution |
| shift | input | 4 | Rate exponent, captured on load |
| coef0 | input | 16 | Offset, integer LSBs, signed |
| coef1 | input | 32 | Slope, 16 fractional bits, signed |
| coef2 | input | 48 | Curvature term, 32 fractional bits, signed |
| coef3 | input | 48 | Jerk term, 32 fractional bits, signed |
| sample | output | 16 | Signed DAC sample |

## Verification
The bench first drives a constant offset with the line idle. This separates load behaviour from evolution. Integer and half-LSB ramps at full rate show whether each coefficient sits at its intended bit position. A ramp at exponent 2 with `active` dropped part way shows whether the rate count pauses correctly and whether a `shift` change outside a load is ignored. A cubic with fractional curvature and a negative jerk, plus ramps that cross the signed boundary in both directions, expose any ordering error in the simultaneous update and any truncated carry. A reload in the middle of a running line confirms that load takes priority over stepping.

// File: rtl/spl_pkg.sv
package spl_pkg;
   // highest polynomial order handled by the accumulator chain
   localparam int unsigned SPL_ORDER = 3;

   // coefficient width in words for a given order: 1, 2, 3, 3
   function automatic int unsigned spl_words(input int unsigned order);
      if (order == 0)      return 1;
      else if (order == 1) return 2;
      else                 return 3;
   endfunction
endpackage

// File: rtl/spl_prescaler.sv
module spl_prescaler #(
   parameter int unsigned SHIFT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               active,
   input  logic [SHIFT_W-1:0] shift,
   output logic [SHIFT_W-1:0] rate_q,
   output logic               step
);
   localparam int unsigned CNT_W = 1 << SHIFT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   generate
      if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad
         $error("spl_prescaler: SHIFT_W out of range");
      end
   endgenerate

   always_comb begin
      mask = (CNT_W'(1) << rate_q) - CNT_W'(1);
      step = active && !load && (cnt_q == mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rate_q <= '0;
      end else if (load) begin
         cnt_q  <= '0;
         rate_q <= shift;
      end else if (active) begin
         if (step) cnt_q <= '0;
         else      cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/spl_acc_stage.sv
module spl_acc_stage #(
   parameter int unsigned ACC_W    = 48,
   parameter bit          HAS_NEXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [ACC_W-1:0] seed,
   input  logic [ACC_W-1:0] nxt,
   output logic [ACC_W-1:0] q
);
   generate
      if (HAS_NEXT) begin : g_sum
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= seed;
            else if (step) q <= q + nxt;
         end
      end else begin : g_const
         logic unused_nxt;
         assign unused_nxt = ^{nxt, step};
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= seed;
         end
      end
   endgenerate
endmodule

// File: rtl/spline_interp.sv
module spline_interp #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned SHIFT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                active,
   input  logic [SHIFT_W-1:0]  shift,
   input  logic [WORD_W-1:0]   coef0,
   input  logic [2*WORD_W-1:0] coef1,
   input  logic [3*WORD_W-1:0] coef2,
   input  logic [3*WORD_W-1:0] coef3,
   output logic [WORD_W-1:0]   sample
);
   import spl_pkg::*;

   localparam int unsigned ACC_W = WORD_W * spl_words(SPL_ORDER);
   localparam int unsigned N_ACC = SPL_ORDER + 1;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spline_interp: WORD_W too small");
      end
   endgenerate

   logic [ACC_W-1:0]   seed [N_ACC];
   logic [ACC_W-1:0]   acc  [N_ACC];
   logic               step;
   logic [SHIFT_W-1:0] rate_q;

   // align every coefficient so its integer part lands on the output word
   always_comb begin
      seed[0] = {coef0, {(ACC_W - WORD_W){1'b0}}};
      seed[1] = {coef1, {(ACC_W - 2*WORD_W){1'b0}}};
      seed[2] = coef2;
      seed[3] = coef3;
   end

   spl_prescaler #(.SHIFT_W(SHIFT_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .active (active),
      .shift  (shift),
      .rate_q (rate_q),
      .step   (step)
   );

   generate
      for (genvar k = 0; k < N_ACC; k++) begin : g_acc
         if (k < N_ACC - 1) begin : g_mid
            spl_acc_stage #(.ACC_W(ACC_W), .HAS_NEXT(1'b1)) u_stage (
               .clk (clk), .rst_n (rst_n), .load (load), .step (step),
               .seed (seed[k]), .nxt (acc[k+1]), .q (acc[k])
            );
         end else begin : g_top
            spl_acc_stage #(.ACC_W(ACC_W), .HAS_NEXT(1'b0)) u_stage (
               .clk (clk), .rst_n (rst_n), .load (load), .step (step),
               .seed (seed[k]), .nxt ('0), .q (acc[k])
            );
         end
      end
   endgenerate

   assign sample = acc[0][ACC_W-1 -: WORD_W];
endmodule

// File: rtl/spl_chk.sv
module spl_chk #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned SHIFT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load,
   input logic               active,
   input logic [WORD_W-1:0]  coef0,
   input logic [WORD_W-1:0]  sample,
   input logic               step,
   input logic [SHIFT_W-1:0] rate_q
);
   AST_LOAD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> sample == $past(coef0));                          // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !active) |=> $stable(sample));                   // R6
   AST_CHANGE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(sample));                     // R3
   AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && rate_q == '0) |-> step);               // R5
   AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !step);                                        // R6
   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> sample == '0);                                  // R1
endmodule

bind spline_interp spl_chk #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load   (load),
   .active (active),
   .coef0  (coef0),
   .sample (sample),
   .step   (step),
   .rate_q (rate_q)
);

// File: tb/sim_spline_interp.sv
module sim_spline_interp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        active = 1'b0;
   logic [3:0]  shift = '0;
   logic [15:0] coef0 = '0;
   logic [31:0] coef1 = '0;
   logic [47:0] coef2 = '0;
   logic [47:0] coef3 = '0;
   logic [15:0] sample;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   // reference model state
   logic [47:0] m0 = '0, m1 = '0, m2 = '0, m3 = '0;
   logic [3:0]  mshift = '0;
   int          mcnt = 0;

   always #5 clk = ~clk;

   spline_interp u0 (
      .clk (clk), .rst_n (rst_n), .load (load), .active (active),
      .shift (shift), .coef0 (coef0), .coef1 (coef1), .coef2 (coef2),
      .coef3 (coef3), .sample (sample)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: sample=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic drive(input bit ld, input bit act, input logic [3:0] sh,
                        input logic [15:0] a0, input logic [31:0] a1,
                        input logic [47:0] a2, input logic [47:0] a3,
                        input string tag);
      @(negedge clk);
      load = ld; active = act; shift = sh;
      coef0 = a0; coef1 = a1; coef2 = a2; coef3 = a3;
      if (ld) begin
         m0 = {a0, 32'h0}; m1 = {a1, 16'h0}; m2 = a2; m3 = a3;
         mshift = sh; mcnt = 0;
      end else if (act) begin
         if (mcnt == (1 << mshift) - 1) begin
            m0 = m0 + m1; m1 = m1 + m2; m2 = m2 + m3; mcnt = 0;
         end else begin
            mcnt++;
         end
      end
      exp_q.push_back(m0[47:32]);
      tag_q.push_back(tag);
   endtask

   task automatic run(input int n, input bit act, input string tag);
      for (int i = 0; i < n; i++)
         drive(1'b0, act, 4'hF, 16'hDEAD, 32'hBEEF_0000, 48'h1, 48'h1, tag);
   endtask

   // monitor: pops one expected item per cycle after the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() != 0) begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(sample, e, t);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: sample=%h expected=completion", sample);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sample, 16'h0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      #3 check(sample, 16'h0, "R1 after release");

      // R2 R6: offset only, idle line holds it
      drive(1'b1, 1'b0, 4'd0, 16'h1234, 32'h0001_0000, 48'h0, 48'h0, "R2 load offset");
      run(5, 1'b0, "R6 idle hold");

      // R4 R5: integer ramp at full rate
      drive(1'b1, 1'b1, 4'd0, 16'h0100, 32'h0001_0000, 48'h0, 48'h0, "R2 load ramp");
      run(8, 1'b1, "R4 integer ramp");

      // R4: half-LSB slope
      drive(1'b1, 1'b0, 4'd0, 16'h0010, 32'h0000_8000, 48'h0, 48'h0, "R2 load half");
      run(8, 1'b1, "R4 half slope");

      // R5 R6: exponent 2 with a pause in the middle
      drive(1'b1, 1'b0, 4'd2, 16'h0000, 32'h0003_0000, 48'h0, 48'h0, "R2 load slow");
      run(6, 1'b1, "R5 slow ramp");
      run(5, 1'b0, "R6 pause");
      run(10, 1'b1, "R5 resume");

      // R3 R8: cubic with fractional curvature and negative jerk, exponent 1
      drive(1'b1, 1'b0, 4'd1, 16'hFF00, 32'h0002_0000, 48'h0000_4000_0000,
            48'hFFFF_FF00_0000, "R2 load cubic");
      run(40, 1'b1, "R8 cubic");

      // R3: curvature only, full rate
      drive(1'b1, 1'b0, 4'd0, 16'h0000, 32'h0000_0000, 48'h0001_0000_0000, 48'h0, "R2 load quad");
      run(10, 1'b1, "R3 quadratic");

      // R7: wrap upward and downward through the signed boundary
      drive(1'b1, 1'b0, 4'd0, 16'h7FFF, 32'h0001_0000, 48'h0, 48'h0, "R2 load wrap up");
      run(3, 1'b1, "R7 wrap up");
      drive(1'b1, 1'b0, 4'd0, 16'h8001, 32'hFFFF_0000, 48'h0, 48'h0, "R2 load wrap down");
      run(3, 1'b1, "R7 wrap down");

      // R2: reload while a line is running takes priority over stepping
      drive(1'b1, 1'b1, 4'd0, 16'h0200, 32'h0010_0000, 48'h0, 48'h0, "R2 load run");
      run(3, 1'b1, "R5 before reload");
      drive(1'b1, 1'b1, 4'd0, 16'h0050, 32'h0001_0000, 48'h0, 48'h0, "R2 reload mid-line");
      run(3, 1'b1, "R5 after reload");

      @(negedge clk);
      load = 1'b0; active = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule